// File: doc/BRIEF.md
# USB Host Port Line-State Control Registers

This block is a small bank of control and status registers for one USB host port. Each 32-bit write carries its own per-bit write enables in bits 31:16, so that software can update a single field, such as the port suspend code or the output clock enable, without reading the word first. The bank drives the port suspend code, an exact-match "port suspended" flag and the output clock enable straight out to the PHY-side logic.

The block also watches the two-bit UTMI line state and the host-disconnect flag. Both pass through a synchroniser and can be read back. While line-state detection is enabled, any change of the synchronised line state sets a sticky status bit. That bit raises an interrupt until software clears it by writing a one to a separate clear bit. A port-management routine typically enables detection while the port is suspended, takes the interrupt when a device attaches, clears the status and resumes the port.

Writes take effect at the clock edge on which `bus_wr` is high. Reads are combinational from `bus_addr`. Addresses are word indices: 0 control, 1 detect enable, 2 status, 3 clear, 4 line state.

Top module: `usbh_port_csr`

## Requirements
- R1: A write to address 0 changes data bit n (n < 16) only where bit n+16 of the written word is 1. The suspend code sits in bits 1:0 and the clock enable in bit 8, so a write whose bit 24 is 0 leaves the clock enable unchanged, and a write whose bits 17:16 are 0 leaves the suspend code unchanged.
- R2: After reset the suspend code is 2, the clock enable is 0, the detect enable (address 1, bit 0) is 0, the status (address 2, bit 0) is 0 and `det_irq` is 0. Address 0 therefore reads 0x00000002.
- R3: `port_suspended` is 1 only when the suspend code equals 2 exactly. The codes 0, 1 and 3 give 0.
- R4: With detect enable at 1, a change on `utmi_ls` sampled at clock edge k sets the status bit from clock edge k+2 on.
- R5: While detect enable is 0, line-state changes leave the status bit at 0.
- R6: The status bit stays set until a write to address 3 has bits 0 and 16 both at 1. A write to address 3 with bit 16 at 0 has no effect. Address 3 reads 0.
- R7: When a clear write and a new line-state change meet on the same clock edge, the status bit ends up set.
- R8: `det_irq` is 1 exactly when the status bit and the detect enable are both 1. Clearing the enable masks the interrupt but keeps the status bit.
- R9: Address 4 returns the line state sampled at edge k in bits 1:0 and the disconnect flag in bit 2, both from edge k+1 on. All other bits read 0.
- R10: Writes to addresses 2 and 4 change nothing. Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W (3) | Word address of the access |
| bus_wdata | input | 32 | Write word: bits 31:16 are per-bit enables for bits 15:0 |
| bus_rdata | output | 32 | Read data of the addressed word |
| utmi_ls | input | 2 | Asynchronous UTMI line state |
| utmi_disc | input | 1 | Asynchronous host-disconnect flag |
| susp_field | output | SUSP_W (2) | Current port suspend code |
| port_suspended | output | 1 | Suspend code equals the suspend encoding |
| clk_out_en | output | 1 | Output clock enable |
| det_irq | output | 1 | Line-state detect interrupt |

## Verification
The masked writes are tried with partial masks, full masks and empty masks over each suspend code. These patterns separate correct per-bit merging from whole-word writes and from ignoring the mask. Line-state toggles are applied once with detection off and once with it on, which separates gating from free-running capture. Clears are applied without the mask bit, with it, and on the same edge as a fresh change, which shows whether the mask is honoured and which side wins the set/clear race. A reference model checks every cycle, so any change in the synchroniser depth shows up as a one-cycle timing mismatch.

// File: rtl/usbh_csr_pkg.sv
package usbh_csr_pkg;
   localparam int unsigned MASK_SHIFT = 16;
   localparam int unsigned DATA_BITS  = 16;
   localparam int unsigned ADDR_CTRL  = 0;
   localparam int unsigned ADDR_DET   = 1;
   localparam int unsigned ADDR_STAT  = 2;
   localparam int unsigned ADDR_CLR   = 3;
   localparam int unsigned ADDR_LINE  = 4;
   localparam int unsigned LS_W       = 2;
endpackage

// File: rtl/usbh_csr_sync.sv
module usbh_csr_sync #(
   parameter int unsigned W      = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("usbh_csr_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q[s] <= '0;
         end else begin
            if (s == 0) stage_q[s] <= d;
            else        stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
         end
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/usbh_csr_field.sv
module usbh_csr_field #(
   parameter int unsigned   W   = 1,
   parameter logic [W-1:0]  RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wr_mask,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] q
);
   if (W < 1 || W > 16) begin : g_bad_width
      $error("usbh_csr_field: W out of range");
   end

   logic [W-1:0] q_next;

   always_comb begin
      q_next = (q & ~wr_mask) | (wr_data & wr_mask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST;
      else if (we) q <= q_next;
   end
endmodule

// File: rtl/usbh_csr_lsdet.sv
module usbh_csr_lsdet #(
   parameter int unsigned LS_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [LS_W-1:0] ls_sync,
   input  logic            det_en,
   input  logic            clr_hit,
   output logic [LS_W-1:0] ls_prev,
   output logic            status
);
   logic change;

   always_comb begin
      change = det_en && (ls_sync != ls_prev);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ls_prev <= '0;
         status  <= 1'b0;
      end else begin
         ls_prev <= ls_sync;
         // a fresh change outranks a clear on the same edge
         status  <= (status && !clr_hit) || change;
      end
   end
endmodule

// File: rtl/usbh_port_csr.sv
module usbh_port_csr
   import usbh_csr_pkg::*;
#(
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned SUSP_W      = 2,
   parameter int unsigned SUSP_LSB    = 0,
   parameter int unsigned SUSP_ON     = 2,
   parameter int unsigned CLK_BIT     = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [1:0]        utmi_ls,
   input  logic              utmi_disc,
   output logic [SUSP_W-1:0] susp_field,
   output logic              port_suspended,
   output logic              clk_out_en,
   output logic              det_irq
);
   localparam int unsigned SYNC_W = LS_W + 1;
   localparam logic [SUSP_W-1:0] SUSP_CODE = SUSP_W'(SUSP_ON);

   if (ADDR_W < 3) begin : g_bad_addr
      $error("usbh_port_csr: ADDR_W must be at least 3");
   end
   if (SUSP_W < 1 || SUSP_LSB + SUSP_W > DATA_BITS) begin : g_bad_susp
      $error("usbh_port_csr: suspend field does not fit");
   end
   if (CLK_BIT >= DATA_BITS ||
       (CLK_BIT >= SUSP_LSB && CLK_BIT < SUSP_LSB + SUSP_W)) begin : g_bad_clk
      $error("usbh_port_csr: clock enable bit overlaps or is out of range");
   end
   if (SUSP_ON >= (1 << SUSP_W)) begin : g_bad_code
      $error("usbh_port_csr: suspend code does not fit the field");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("usbh_port_csr: at least two synchroniser stages required");
   end

   // ---------------- write decode ----------------
   logic sel_ctrl, sel_det, clr_hit;
   logic unused_wdata;

   always_comb begin
      sel_ctrl = bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL));
      sel_det  = bus_wr && (bus_addr == ADDR_W'(ADDR_DET));
      clr_hit  = bus_wr && (bus_addr == ADDR_W'(ADDR_CLR))
                 && bus_wdata[MASK_SHIFT] && bus_wdata[0];
   end
   assign unused_wdata = ^bus_wdata;

   // ---------------- control fields ----------------
   logic det_en_q;

   usbh_csr_field #(.W(SUSP_W), .RST(SUSP_CODE)) u_susp (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (sel_ctrl),
      .wr_mask (bus_wdata[MASK_SHIFT+SUSP_LSB +: SUSP_W]),
      .wr_data (bus_wdata[SUSP_LSB +: SUSP_W]),
      .q       (susp_field)
   );

   usbh_csr_field #(.W(1), .RST(1'b0)) u_clk (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (sel_ctrl),
      .wr_mask (bus_wdata[MASK_SHIFT+CLK_BIT]),
      .wr_data (bus_wdata[CLK_BIT]),
      .q       (clk_out_en)
   );

   usbh_csr_field #(.W(1), .RST(1'b0)) u_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (sel_det),
      .wr_mask (bus_wdata[MASK_SHIFT]),
      .wr_data (bus_wdata[0]),
      .q       (det_en_q)
   );

   // ---------------- line-state path ----------------
   logic [SYNC_W-1:0] sync_q;
   logic [LS_W-1:0]   ls_sync, ls_prev;
   logic              disc_sync, status_q;

   usbh_csr_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({utmi_disc, utmi_ls}),
      .q     (sync_q)
   );

   assign ls_sync   = sync_q[LS_W-1:0];
   assign disc_sync = sync_q[LS_W];

   usbh_csr_lsdet #(.LS_W(LS_W)) u_det_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .ls_sync (ls_sync),
      .det_en  (det_en_q),
      .clr_hit (clr_hit),
      .ls_prev (ls_prev),
      .status  (status_q)
   );

   // ---------------- outputs ----------------
   assign port_suspended = (susp_field == SUSP_CODE);
   assign det_irq        = status_q && det_en_q;

   always_comb begin
      bus_rdata = '0;
      unique case (int'(bus_addr))
         ADDR_CTRL: begin
            bus_rdata[SUSP_LSB +: SUSP_W] = susp_field;
            bus_rdata[CLK_BIT]            = clk_out_en;
         end
         ADDR_DET:  bus_rdata[0] = det_en_q;
         ADDR_STAT: bus_rdata[0] = status_q;
         ADDR_LINE: bus_rdata[SYNC_W-1:0] = {disc_sync, ls_sync};
         default:   bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/usbh_port_csr_chk.sv
module usbh_port_csr_chk #(
   parameter int unsigned ADDR_W   = 3,
   parameter int unsigned SUSP_W   = 2,
   parameter int unsigned SUSP_LSB = 0,
   parameter int unsigned CLK_BIT  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              clk_out_en,
   input logic [SUSP_W-1:0] susp_field,
   input logic              det_en,
   input logic              status,
   input logic              clr_hit,
   input logic [1:0]        ls_sync,
   input logic [1:0]        ls_prev,
   input logic              det_irq
);
   a_r1_clk_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == '0 && !bus_wdata[16+CLK_BIT]) |=> $stable(clk_out_en));

   a_r1_susp_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == '0 && bus_wdata[16+SUSP_LSB +: SUSP_W] == '0)
      |=> $stable(susp_field));

   a_r4_sets_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      (det_en && ls_sync != ls_prev) |=> status);

   a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!det_en && !status) |=> !status);

   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status && !clr_hit) |=> status);

   a_r6_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && !(det_en && ls_sync != ls_prev)) |=> !status);

   a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
      !det_en |-> !det_irq);

   a_r8_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
      det_irq |-> status);
endmodule

bind usbh_port_csr usbh_port_csr_chk #(
   .ADDR_W   (ADDR_W),
   .SUSP_W   (SUSP_W),
   .SUSP_LSB (SUSP_LSB),
   .CLK_BIT  (CLK_BIT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .clk_out_en (clk_out_en),
   .susp_field (susp_field),
   .det_en     (det_en_q),
   .status     (status_q),
   .clr_hit    (clr_hit),
   .ls_sync    (ls_sync),
   .ls_prev    (ls_prev),
   .det_irq    (det_irq)
);

// File: tb/usbh_port_csr_test.sv
module usbh_port_csr_test;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  utmi_ls = 2'd0;
   logic        utmi_disc = 1'b0;
   logic [1:0]  susp_field;
   logic        port_suspended, clk_out_en, det_irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   usbh_port_csr uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .utmi_ls(utmi_ls),
      .utmi_disc(utmi_disc), .susp_field(susp_field),
      .port_suspended(port_suspended), .clk_out_en(clk_out_en), .det_irq(det_irq)
   );

   // ---------------- behavioural reference ----------------
   int         pipe[$];   // newest sample at front, synchronised value at back
   int         m_prev;
   bit         m_en, m_stat, m_clk;
   logic [1:0] m_susp;

   always @(posedge clk) begin
      if (!rst_n) begin
         pipe = '{0, 0};
         m_prev = 0; m_en = 0; m_stat = 0; m_clk = 0; m_susp = 2'd2;
      end else begin
         bit ev, clr;
         int seen;
         seen = pipe[$];
         ev  = m_en && ((seen & 3) != m_prev);
         clr = bus_wr && bus_addr == 3'd3 && bus_wdata[16] && bus_wdata[0];
         m_stat = (m_stat && !clr) || ev;
         m_prev = seen & 3;
         pipe.push_front({29'd0, utmi_disc, utmi_ls});
         void'(pipe.pop_back());
         if (bus_wr && bus_addr == 3'd0) begin
            for (int i = 0; i < 2; i++) if (bus_wdata[16+i]) m_susp[i] = bus_wdata[i];
            if (bus_wdata[24]) m_clk = bus_wdata[8];
         end
         if (bus_wr && bus_addr == 3'd1 && bus_wdata[16]) m_en = bus_wdata[0];
      end
   end

   function automatic logic [31:0] exp_rd(input logic [2:0] a);
      case (a)
         3'd0: return {23'd0, m_clk, 6'd0, m_susp};
         3'd1: return {31'd0, m_en};
         3'd2: return {31'd0, m_stat};
         3'd4: return pipe[$];
         default: return 32'd0;
      endcase
   endfunction

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         bit bad;
         bad = 0;
         n_checks++;
         if (bus_rdata !== exp_rd(bus_addr)) begin
            bad = 1;
            $display("FAIL R9/R10 read addr %0d: actual %h expected %h", bus_addr, bus_rdata, exp_rd(bus_addr));
         end
         if (susp_field !== m_susp || port_suspended !== (m_susp == 2'd2)) begin
            bad = 1;
            $display("FAIL R1/R3 suspend: actual %0d/%0b expected %0d/%0b",
                     susp_field, port_suspended, m_susp, (m_susp == 2'd2));
         end
         if (clk_out_en !== m_clk) begin
            bad = 1;
            $display("FAIL R1 clock enable: actual %0b expected %0b", clk_out_en, m_clk);
         end
         if (det_irq !== (m_stat && m_en)) begin
            bad = 1;
            $display("FAIL R8 irq: actual %0b expected %0b", det_irq, m_stat && m_en);
         end
         if (bad) n_fail++;
      end
   end

   // ---------------- helpers ----------------
   task automatic check(input bit ok, input string tag, input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd_check(input logic [2:0] a, input logic [31:0] expv, input string tag);
      @(posedge clk); #1;
      bus_addr = a;
      @(negedge clk);
      check(bus_rdata === expv, tag, bus_rdata, expv);
   endtask

   task automatic set_line(input logic [1:0] v, input logic disc);
      @(posedge clk); #1;
      utmi_ls = v; utmi_disc = disc;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // reset state
      rd_check(3'd0, 32'h0000_0002, "R2 control after reset");
      check(port_suspended === 1'b1 && clk_out_en === 1'b0, "R2 suspended, clock off",
            {port_suspended, clk_out_en}, 2'b10);
      rd_check(3'd1, 32'h0, "R2 detect enable after reset");
      rd_check(3'd2, 32'h0, "R2 status after reset");
      check(det_irq === 1'b0, "R2 irq after reset", det_irq, 0);

      // masked writes to the suspend code
      wr(3'd0, 32'h0001_0003);
      rd_check(3'd0, 32'h0000_0003, "R1 only bit 0 written");
      check(port_suspended === 1'b0, "R3 code 3 not suspended", port_suspended, 0);
      wr(3'd0, 32'h0003_0001);
      check(susp_field === 2'd1 && port_suspended === 1'b0, "R3 code 1 resumes",
            {susp_field, port_suspended}, 3'b010);
      wr(3'd0, 32'h0003_0000);
      check(port_suspended === 1'b0, "R3 code 0 not suspended", port_suspended, 0);
      wr(3'd0, 32'h0003_0002);
      check(port_suspended === 1'b1, "R3 code 2 suspended", port_suspended, 1);
      wr(3'd0, 32'h0100_01FF);
      rd_check(3'd0, 32'h0000_0102, "R1 clock enable without touching suspend");
      wr(3'd0, 32'h0000_0000);
      check(clk_out_en === 1'b1, "R1 empty mask keeps clock enable", clk_out_en, 1);

      // detection disabled
      set_line(2'd1, 1'b0);
      set_line(2'd2, 1'b1);
      repeat (4) @(posedge clk);
      rd_check(3'd2, 32'h0, "R5 no status while disabled");
      rd_check(3'd4, 32'h0000_0006, "R9 line word shows state and disconnect");

      // detection enabled: exact latency
      wr(3'd1, 32'h0001_0001);
      @(posedge clk); #1;
      bus_addr = 3'd2;
      utmi_ls = 2'd1;
      repeat (3) @(negedge clk);
      check(bus_rdata[0] === 1'b0, "R4 status not yet set two edges later", bus_rdata[0], 0);
      @(negedge clk);
      check(bus_rdata[0] === 1'b1 && det_irq === 1'b1, "R4 status and irq set on third edge",
            {bus_rdata[0], det_irq}, 2'b11);

      // sticky until a masked clear
      set_line(2'd1, 1'b0);
      repeat (4) @(posedge clk);
      wr(3'd3, 32'h0000_0001);
      rd_check(3'd2, 32'h1, "R6 clear without mask ignored");
      rd_check(3'd3, 32'h0, "R6 clear word reads zero");
      wr(3'd3, 32'h0001_0001);
      rd_check(3'd2, 32'h0, "R6 masked clear");

      // set and clear on the same edge
      @(posedge clk); #1;
      utmi_ls = 2'd0;
      @(posedge clk); #1;
      @(posedge clk); #1;
      bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = 32'h0001_0001;
      @(posedge clk); #1;
      bus_wr = 1'b0;
      rd_check(3'd2, 32'h1, "R7 change beats clear");

      // masking the interrupt
      wr(3'd1, 32'h0001_0000);
      check(det_irq === 1'b0, "R8 irq masked when disabled", det_irq, 0);
      rd_check(3'd2, 32'h1, "R8 status kept when disabled");
      wr(3'd1, 32'h0001_0001);
      check(det_irq === 1'b1, "R8 irq back when re-enabled", det_irq, 1);

      // read-only words and unused addresses
      wr(3'd2, 32'hFFFF_0000);
      rd_check(3'd2, 32'h1, "R10 status write ignored");
      wr(3'd4, 32'hFFFF_FFFF);
      rd_check(3'd4, 32'h0000_0000, "R10 line write ignored");
      rd_check(3'd5, 32'h0, "R10 address 5 reads zero");
      rd_check(3'd7, 32'h0, "R10 address 7 reads zero");

      repeat (2) @(posedge clk);
      finish_run();
   end
endmodule